// File: doc/BRIEF.md
# Five-Valued Fault-Propagation Gate Evaluator

This block evaluates one logic gate over the five-valued algebra that test-pattern generators use to follow a fault through a circuit. Each operand carries one of five values: logic 0, logic 1, unknown (X), D and D-bar. D is a value that is 1 in the fault-free circuit and 0 in the faulty one. D-bar is the reverse: 0 when fault-free and 1 when faulty. An opcode selects a buffer, an inverter, or a two-input AND, OR, NAND or NOR. The block first turns each operand into a fault-free/faulty bit pair with an unknown flag. It then computes the gate on that pair and encodes the result back into the 3-bit value code.

A stuck-at fault can be injected at the gate output. The fault-free half of the value is kept, and the faulty half is forced to the stuck polarity. This turns an excited node into D or D-bar. An unknown value is left unchanged. A clocked wrapper captures each accepted vector and presents its result one cycle later, with a valid flag that follows the input valid. A search engine can issue one gate evaluation per cycle to this block.

Top module: `dcalc_gate_eval`

## Requirements
- R1: Value codes are 0=3'b000, 1=3'b001, X=3'b010, D=3'b011, D-bar=3'b100. An operand code of 3'b101, 3'b110 or 3'b111 is read as X. The result is always one of the five legal codes.
- R2: AND: a 0 on either input gives 0, whatever the other input is (X, D or D-bar included). A 1 passes the other input through. Equal inputs pass through. D with D-bar gives 0. Any other combination that involves X gives X.
- R3: OR: a 1 on either input gives 1. A 0 passes the other input through. Equal inputs pass through. D with D-bar gives 1. Any other combination that involves X gives X.
- R4: The inverter maps 0 to 1, 1 to 0, D to D-bar, D-bar to D and X to X. The buffer passes its input through. Both use operand A only.
- R5: NAND equals the inverse of AND, and NOR equals the inverse of OR, on all operand pairs.
- R6: Opcodes are 3'b000 buffer, 3'b001 inverter, 3'b010 AND, 3'b011 OR, 3'b100 NAND, 3'b101 NOR. Opcodes 3'b110 and 3'b111 give X.
- R7: With injection enabled and stuck_in=0 (stuck-at-0), a gate result of 1 becomes D and D-bar becomes 0. Results 0, X and D are unchanged.
- R8: With injection enabled and stuck_in=1 (stuck-at-1), a gate result of 0 becomes D-bar and D becomes 1. Results 1, X and D-bar are unchanged.
- R9: With inj_en_in=0, the result equals the gate result for either value of stuck_in.
- R10: A vector presented with valid_in=1 at a rising edge appears on result_out with valid_out=1 right after that edge. valid_out is low after any edge at which valid_in was low.
- R11: After reset, valid_out=0 and result_out=3'b000. result_out holds its value across cycles in which valid_in is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Vector on the inputs is to be evaluated |
| op_in | input | 3 | Gate opcode |
| a_in | input | 3 | Operand A value code |
| b_in | input | 3 | Operand B value code |
| inj_en_in | input | 1 | Enable stuck-at injection at the gate output |
| stuck_in | input | 1 | Stuck polarity: 0 stuck-at-0, 1 stuck-at-1 |
| valid_out | output | 1 | result_out carries a new result |
| result_out | output | 3 | Encoded five-valued result |

## Verification
The only state is the captured result and its valid flag, so any fault shows up one cycle after the vector that causes it. A wrong captured code gives a mismatched value on result_out in the cycle valid_out rises. A stale or dropped flag shifts the pairing between pushed expectations and observed results, and the pairing stays broken from that point on. A result register that loads while valid_in is low shows up as a changed result_out in a cycle with valid_out low. Every operand code, including the three unused ones, is driven under every opcode. Injection is swept over all five values and both polarities, so each entry of the truth tables is observed directly.

// File: rtl/dcalc_pkg.sv
package dcalc_pkg;

    localparam int CODE_W = 3;
    localparam int OP_W   = 3;
    localparam int N_OPND = 2;

    localparam logic [CODE_W-1:0] C_ZERO = 3'b000;
    localparam logic [CODE_W-1:0] C_ONE  = 3'b001;
    localparam logic [CODE_W-1:0] C_UNK  = 3'b010;
    localparam logic [CODE_W-1:0] C_DG   = 3'b011;
    localparam logic [CODE_W-1:0] C_DB   = 3'b100;

    localparam logic [OP_W-1:0] OP_BUF  = 3'b000;
    localparam logic [OP_W-1:0] OP_INV  = 3'b001;
    localparam logic [OP_W-1:0] OP_AND  = 3'b010;
    localparam logic [OP_W-1:0] OP_OR   = 3'b011;
    localparam logic [OP_W-1:0] OP_NAND = 3'b100;
    localparam logic [OP_W-1:0] OP_NOR  = 3'b101;

    // Composite value: unknown flag, fault-free bit, faulty bit.
    typedef struct packed {
        logic unk;
        logic good;
        logic bad;
    } pair_t;

    localparam pair_t P_UNK = '{unk: 1'b1, good: 1'b0, bad: 1'b0};

    function automatic logic p_is(pair_t p, logic v);
        return !p.unk && (p.good == v) && (p.bad == v);
    endfunction

    function automatic pair_t p_not(pair_t p);
        pair_t r;
        if (p.unk) r = P_UNK;
        else       r = '{unk: 1'b0, good: ~p.good, bad: ~p.bad};
        return r;
    endfunction

    function automatic pair_t p_and(pair_t a, pair_t b);
        pair_t r;
        if (p_is(a, 1'b0) || p_is(b, 1'b0)) r = '{unk: 1'b0, good: 1'b0, bad: 1'b0};
        else if (a.unk || b.unk)            r = P_UNK;
        else                                r = '{unk: 1'b0, good: a.good & b.good, bad: a.bad & b.bad};
        return r;
    endfunction

    function automatic pair_t p_or(pair_t a, pair_t b);
        pair_t r;
        if (p_is(a, 1'b1) || p_is(b, 1'b1)) r = '{unk: 1'b0, good: 1'b1, bad: 1'b1};
        else if (a.unk || b.unk)            r = P_UNK;
        else                                r = '{unk: 1'b0, good: a.good | b.good, bad: a.bad | b.bad};
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] p_encode(pair_t p);
        logic [CODE_W-1:0] c;
        if (p.unk)                c = C_UNK;
        else if (p.good == p.bad) c = p.good ? C_ONE : C_ZERO;
        else if (p.good)          c = C_DG;
        else                      c = C_DB;
        return c;
    endfunction

endpackage

// File: rtl/dcalc_operand_decode.sv
module dcalc_operand_decode
    import dcalc_pkg::*;
#(
    parameter int NUM = N_OPND
) (
    input  logic [NUM*CODE_W-1:0] codes_in,
    output pair_t [NUM-1:0]       pairs_out
);

    for (genvar i = 0; i < NUM; i++) begin : g_dec
        logic [CODE_W-1:0] code;
        assign code = codes_in[i*CODE_W +: CODE_W];

        always_comb begin
            unique case (code)
                C_ZERO:  pairs_out[i] = '{unk: 1'b0, good: 1'b0, bad: 1'b0};
                C_ONE:   pairs_out[i] = '{unk: 1'b0, good: 1'b1, bad: 1'b1};
                C_DG:    pairs_out[i] = '{unk: 1'b0, good: 1'b1, bad: 1'b0};
                C_DB:    pairs_out[i] = '{unk: 1'b0, good: 1'b0, bad: 1'b1};
                default: pairs_out[i] = P_UNK;
            endcase
        end
    end

endmodule

// File: rtl/dcalc_gate_core.sv
module dcalc_gate_core
    import dcalc_pkg::*;
(
    input  logic [OP_W-1:0] op_in,
    input  pair_t           a_in,
    input  pair_t           b_in,
    output pair_t           y_out
);

    pair_t and_p;
    pair_t or_p;

    always_comb begin
        and_p = p_and(a_in, b_in);
        or_p  = p_or(a_in, b_in);
        unique case (op_in)
            OP_BUF:  y_out = a_in.unk ? P_UNK : a_in;
            OP_INV:  y_out = p_not(a_in);
            OP_AND:  y_out = and_p;
            OP_OR:   y_out = or_p;
            OP_NAND: y_out = p_not(and_p);
            OP_NOR:  y_out = p_not(or_p);
            default: y_out = P_UNK;
        endcase
    end

endmodule

// File: rtl/dcalc_fault_inject.sv
module dcalc_fault_inject
    import dcalc_pkg::*;
(
    input  pair_t node_in,
    input  logic  en_in,
    input  logic  stuck_in,
    output pair_t node_out
);

    // The faulty half is forced to the stuck level; an unknown stays unknown.
    always_comb begin
        node_out = node_in;
        if (en_in && !node_in.unk) begin
            node_out.bad = stuck_in;
        end
    end

endmodule

// File: rtl/dcalc_gate_eval.sv
module dcalc_gate_eval
    import dcalc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [OP_W-1:0]   op_in,
    input  logic [CODE_W-1:0] a_in,
    input  logic [CODE_W-1:0] b_in,
    input  logic              inj_en_in,
    input  logic              stuck_in,
    output logic              valid_out,
    output logic [CODE_W-1:0] result_out
);

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] res;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    pair_t [N_OPND-1:0] opnd;
    pair_t            gate_y;
    pair_t            site_y;

    dcalc_operand_decode #(.NUM(N_OPND)) u_dec (
        .codes_in  ({b_in, a_in}),
        .pairs_out (opnd)
    );

    dcalc_gate_core u_core (
        .op_in (op_in),
        .a_in  (opnd[0]),
        .b_in  (opnd[1]),
        .y_out (gate_y)
    );

    dcalc_fault_inject u_inj (
        .node_in  (gate_y),
        .en_in    (inj_en_in),
        .stuck_in (stuck_in),
        .node_out (site_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_in;
        if (valid_in) begin
            st_d.res = p_encode(site_y);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out  = st_q.vld;
    assign result_out = st_q.res;

endmodule

// File: rtl/dcalc_gate_eval_chk.sv
module dcalc_gate_eval_chk
    import dcalc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [OP_W-1:0]   op_in,
    input logic [CODE_W-1:0] a_in,
    input logic [CODE_W-1:0] b_in,
    input logic              inj_en_in,
    input logic              stuck_in,
    input logic              valid_out,
    input logic [CODE_W-1:0] result_out
);

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        result_out <= C_DB);

    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result_out));

    a_r2_and_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !inj_en_in && op_in == OP_AND && (a_in == C_ZERO || b_in == C_ZERO))
        |=> result_out == C_ZERO);

    a_r3_or_one: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !inj_en_in && op_in == OP_OR && (a_in == C_ONE || b_in == C_ONE))
        |=> result_out == C_ONE);

    a_r7_sa0_excite: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && inj_en_in && !stuck_in && op_in == OP_BUF && a_in == C_ONE)
        |=> result_out == C_DG);

    a_r8_sa1_excite: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && inj_en_in && stuck_in && op_in == OP_BUF && a_in == C_ZERO)
        |=> result_out == C_DB);

    a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !inj_en_in && op_in == OP_BUF && a_in <= C_DB)
        |=> result_out == $past(a_in));

endmodule

bind dcalc_gate_eval dcalc_gate_eval_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .op_in      (op_in),
    .a_in       (a_in),
    .b_in       (b_in),
    .inj_en_in  (inj_en_in),
    .stuck_in   (stuck_in),
    .valid_out  (valid_out),
    .result_out (result_out)
);

// File: tb/sim_dcalc_gate_eval.sv
module sim_dcalc_gate_eval;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_in = 1'b0;
    logic [2:0] op_in = '0;
    logic [2:0] a_in = '0;
    logic [2:0] b_in = '0;
    logic       inj_en_in = 1'b0;
    logic       stuck_in = 1'b0;
    logic       valid_out;
    logic [2:0] result_out;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    logic [2:0] last_res = 3'b000;

    typedef struct {
        int    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    dcalc_gate_eval u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_in(op_in),
        .a_in(a_in), .b_in(b_in), .inj_en_in(inj_en_in), .stuck_in(stuck_in),
        .valid_out(valid_out), .result_out(result_out)
    );

    // Reference values: 0, 1, 2=X, 3=D, 4=D-bar (same as the R1 codes).
    function automatic int nrm(int c);
        return (c > 4) ? 2 : c;
    endfunction

    function automatic int r_not(int v);
        case (v)
            0: return 1;
            1: return 0;
            3: return 4;
            4: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int r_and(int a, int b);
        if (a == 0 || b == 0) return 0;
        if (a == 2 || b == 2) return 2;
        if (a == 1) return b;
        if (b == 1) return a;
        if (a == b) return a;
        return 0;
    endfunction

    function automatic int r_or(int a, int b);
        if (a == 1 || b == 1) return 1;
        if (a == 2 || b == 2) return 2;
        if (a == 0) return b;
        if (b == 0) return a;
        if (a == b) return a;
        return 1;
    endfunction

    function automatic int r_gate(int op, int a, int b);
        case (op)
            0: return a;
            1: return r_not(a);
            2: return r_and(a, b);
            3: return r_or(a, b);
            4: return r_not(r_and(a, b));
            5: return r_not(r_or(a, b));
            default: return 2;
        endcase
    endfunction

    function automatic int r_inj(int v, bit en, bit s);
        if (!en) return v;
        if (!s) begin
            if (v == 1) return 3;
            if (v == 4) return 0;
        end else begin
            if (v == 0) return 4;
            if (v == 3) return 1;
        end
        return v;
    endfunction

    function automatic string op_tag(int op, int a, int b);
        if (a > 4 || b > 4) return "R1";
        case (op)
            0, 1: return "R4";
            2:    return "R2";
            3:    return "R3";
            4, 5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(int op, int a, int b, bit en, bit s, string tag);
        item_t it;
        @(negedge clk);
        valid_in  = 1'b1;
        op_in     = 3'(op);
        a_in      = 3'(a);
        b_in      = 3'(b);
        inj_en_in = en;
        stuck_in  = s;
        it.exp = r_inj(r_gate(op, nrm(a), nrm(b)), en, s);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in  = 1'b0;
            op_in     = 3'(i + 2);
            a_in      = 3'(i + 1);
            b_in      = 3'(7 - i);
            inj_en_in = i[0];
            stuck_in  = ~i[0];
        end
    endtask

    // Monitor: pops an expectation per valid result, checks hold otherwise (R10, R11).
    always @(negedge clk) begin
        if (mon_on) begin
            if (valid_out) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected valid_out", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(int'(result_out) == it.exp, it.tag, int'(result_out), it.exp);
                end
                last_res = result_out;
            end else begin
                check(result_out == last_res, "R11 hold", int'(result_out), int'(last_res));
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(valid_out == 1'b0, "R11 reset valid", int'(valid_out), 0);
        check(result_out == 3'b000, "R11 reset result", int'(result_out), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // All opcodes, all operand codes, injection off.
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    drive(op, a, b, 1'b0, bit'(a ^ b), op_tag(op, a, b));
                end
                idle(1 + (a % 3));
            end
        end

        // R9: injection disabled with both polarities.
        for (int v = 0; v < 5; v++) begin
            drive(0, v, 0, 1'b0, 1'b0, "R9");
            drive(0, v, 0, 1'b0, 1'b1, "R9");
        end

        // R7 / R8: injection over every gate result.
        for (int op = 0; op < 6; op++) begin
            for (int a = 0; a < 5; a++) begin
                for (int b = 0; b < 5; b++) begin
                    drive(op, a, b, 1'b1, 1'b0, "R7");
                    drive(op, a, b, 1'b1, 1'b1, "R8");
                end
            end
            idle(2);
        end

        idle(3);
        check(sb.size() == 0, "R10 all results delivered", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule